// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block generates the address sequence of a four-beat burst for a memory access path. A controller loads a full starting address together with the wanted burst order; from then on, each advance pulse moves the burst by one beat. Only the two least-significant address bits take part in the sequence. The upper bits repeat the loaded value until the next load.

Two orders are available. In the interleaved order, the beat index is XORed into the two start bits. In the linear order, the beat index is added to the start bits modulo four. The order is captured at the load and does not change during the burst. The block does not decide when a load or an advance happens; the controller that drives it makes that decision.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, `addr_o` is all zeros, and the stored order is interleaved.
- R2: After a clock edge where `load_i` is high, `addr_o` equals the `start_addr_i` value sampled at that edge, and the beat index is zero.
- R3: The bits of `addr_o` above bit 1 keep their value across every clock edge where `load_i` is low.
- R4: On a clock edge where both `load_i` and `adv_i` are low, `addr_o` keeps its value.
- R5: If `interleave_i` was 1 at the load, then after k advances (k = 0..3), bits [1:0] of `addr_o` equal start[1:0] XOR k.
- R6: If `interleave_i` was 0 at the load, then after k advances, bits [1:0] of `addr_o` equal (start[1:0] + k) mod 4.
- R7: A fifth beat wraps around: four advances after a load bring `addr_o` back to the loaded address, and the cycle then repeats.
- R8: If `load_i` and `adv_i` are high on the same edge, the load wins. `addr_o` becomes the new start address, with beat index zero.
- R9: `interleave_i` is sampled only on load edges; changing it during a burst has no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture a new start address and order |
| start_addr_i | input | ADDR_W | Full starting address of the burst |
| adv_i | input | 1 | Step the burst by one beat |
| interleave_i | input | 1 | Order select at load: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The assertions assume that `load_i`, `adv_i`, `start_addr_i` and `interleave_i` are known (not X) on every clock edge after reset. They also assume that an advance on a burst that has already completed four beats is legal and is meant to wrap. The bench changes every input half a period away from the rising edge and gives each one a defined value from time zero. It drives runs of more than four advances on purpose, so the wrap is exercised as intended traffic.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits for beat k under the chosen order.
  function automatic beat_t beat_addr(input beat_t start, input beat_t k,
                                      input logic interleave);
    beat_t r;
    if (interleave) r = start ^ k;
    else            r = start + k;
    return r;
  endfunction
endpackage

// File: rtl/bas_start_reg.sv
module bas_start_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_in,
  input  logic              mode_in,
  output logic [ADDR_W-1:0] start_q,
  output logic              mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      mode_q  <= 1'b1;
    end else if (load) begin
      start_q <= start_in;
      mode_q  <= mode_in;
    end
  end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  step,
  output beat_t beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     beat_q <= '0;
    else if (clear) beat_q <= '0;
    else if (step)  beat_q <= beat_q + beat_t'(1);
  end
endmodule

// File: rtl/bas_order_mux.sv
module bas_order_mux
  import bas_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] start_q,
  input  logic              mode_q,
  input  beat_t             beat_q,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0] hi_bits;
  beat_t           lo_bits;

  always_comb begin
    hi_bits = start_q[ADDR_W-1:BEAT_W];
    lo_bits = beat_addr(start_q[BEAT_W-1:0], beat_q, mode_q);
    addr    = {hi_bits, lo_bits};
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_i,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] addr_o
);
  // Named events for the checker.
  logic              load_evt;
  logic              step_evt;
  logic [ADDR_W-1:0] start_q;
  logic              mode_q;
  beat_t             beat_q;

  assign load_evt = load_i;
  assign step_evt = adv_i & ~load_i;

  bas_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .start_in (start_addr_i),
    .mode_in  (interleave_i),
    .start_q  (start_q),
    .mode_q   (mode_q)
  );

  bas_beat_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (load_evt),
    .step   (step_evt),
    .beat_q (beat_q)
  );

  bas_order_mux #(.ADDR_W(ADDR_W)) u_mux (
    .start_q (start_q),
    .mode_q  (mode_q),
    .beat_q  (beat_q),
    .addr    (addr_o)
  );
endmodule

// File: rtl/bas_checker.sv
module bas_checker
  import bas_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              step_evt,
  input beat_t             beat_q
);
  always_comb begin
    if (!rst_n) a_reset_zero_r1: assert (addr_o == '0 || $isunknown(addr_o));
  end

  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(start_addr_i)));

  p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(addr_o));

  p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (beat_q == beat_t'($past(beat_q) + beat_t'(1))));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i) |=> (beat_q == '0));
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_bas_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .adv_i        (adv_i),
  .start_addr_i (start_addr_i),
  .addr_o       (addr_o),
  .step_evt     (step_evt),
  .beat_q       (beat_q)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          adv_i = 1'b0;
  logic          interleave_i = 1'b1;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  // Reference state
  logic [AW-1:0] m_base = '0;
  logic          m_mode = 1'b1;
  int            m_k = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
    .adv_i(adv_i), .interleave_i(interleave_i), .addr_o(addr_o)
  );

  function automatic logic [AW-1:0] model_addr();
    int lo;
    lo = m_mode ? (int'(m_base[1:0]) ^ m_k) : ((int'(m_base[1:0]) + m_k) % 4);
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(input logic [AW-1:0] exp, input string tag);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected=%h", tag, addr_o, exp);
    end
  endtask

  // One clock: drive at negedge, update model, sample at next negedge.
  task automatic cycle(input logic ld, input logic adv, input logic [AW-1:0] a,
                       input logic md, input string tag);
    load_i = ld; adv_i = adv; start_addr_i = a; interleave_i = md;
    @(posedge clk);
    if (ld) begin m_base = a; m_mode = md; m_k = 0; end
    else if (adv) m_k = (m_k + 1) % 4;
    @(negedge clk);
    check(model_addr(), tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: expected=finish actual=timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check('0, "R1 reset");
    rst_n = 1'b1;
    cycle(1'b0, 1'b0, '0, 1'b1, "R1 after reset");
    // Default order is interleaved: advances from zero give 1,2,3
    cycle(1'b0, 1'b1, '0, 1'b0, "R1 R9 default interleaved");

    for (int up = 0; up < 3; up++) begin
      for (int md = 0; md < 2; md++) begin
        for (int s = 0; s < 4; s++) begin
          logic [AW-1:0] a;
          a = {16'((up * 16'h5a3c) ^ (s * 16'h0101) ^ 16'hc3a5), 2'(s)};
          cycle(1'b1, 1'b0, a, md[0], "R2 load");
          for (int b = 0; b < 9; b++) begin
            // Hold cycle between beats, toggling the mode pin (R9)
            if (b % 3 == 1)
              cycle(1'b0, 1'b0, ~a, ~md[0], "R4 R9 hold");
            cycle(1'b0, 1'b1, ~a, (b % 2 == 0), md[0] ? "R5 R3 interleaved" : "R6 R3 linear");
            if (b == 3) check(a, "R7 wrap to start");
          end
        end
      end
    end

    // Load and advance on the same edge
    cycle(1'b0, 1'b1, '0, 1'b0, "R8 setup");
    cycle(1'b1, 1'b1, 18'h2abcd, 1'b0, "R8 load wins");
    check(18'h2abcd, "R8 start exact");
    cycle(1'b0, 1'b1, '0, 1'b1, "R6 R8 next beat");
    check(18'h2abce, "R6 linear step");
    cycle(1'b1, 1'b1, 18'h3fffe, 1'b1, "R8 load wins interleaved");
    cycle(1'b0, 1'b1, '0, 1'b0, "R5 after priority");
    check(18'h3ffff, "R5 interleaved step");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule